// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer for 9-bit words. It has a write clock and a read clock that need not be related, and each side has its own enable. Words written on the write side come out on the read side in the same order. Writes into a full buffer and reads from an empty buffer are dropped, so neither pointer can pass the other. Four active-low status outputs report the fill level. Two of them mark the hard limits, empty and full. The other two mark thresholds that software can set: almost-empty and almost-full.

The two thresholds sit in an offset register that is loaded through the data input. While `load` is high, each enabled write-clock edge stores the data word into one part of the offset register instead of the memory. The parts are filled in this order: low part of the almost-empty offset, its high part, low part of the almost-full offset, its high part. After the fourth part the sequence starts again. The read output is registered and keeps its last value whenever no valid read takes place. Read and write pointers cross between the clock domains as Gray code through two-stage synchronizers. Full and almost-full are computed in the write domain, and empty and almost-empty in the read domain.

Top module: `fifo_pf`

## Requirements
- R1: While `rst` is high and after it is released, before any write, `empty_n`=0, `aempty_n`=0, `full_n`=1 and `afull_n`=1. Both offsets take their default value of 8, so with 8 words stored `aempty_n`=0 and with 9 words it is 1.
- R2: Words come out on `q` in the order they were accepted, with all 9 bits intact. This holds across pointer wrap-around and while both sides run at once.
- R3: `full_n` is 0 exactly when DEPTH words are stored. A write while `full_n`=0 is dropped and is never read out.
- R4: `empty_n` is 0 exactly when no words are stored. A read while `empty_n`=0 is dropped, and `q` keeps the value of the last valid read.
- R5: A write with `load`=1 does not enter the memory. The stored word count does not change.
- R6: Load writes fill the offset parts in the order almost-empty low, almost-empty high, almost-full low, almost-full high, then wrap to almost-empty low. A low part takes `din[8:0]` as offset bits [8:0], and a high part supplies offset bits 9 and up. Bits at or above the offset width (9 by default) are ignored, so with the default width a high-part write has no effect.
- R7: `afull_n` is 0 when the stored count is at least DEPTH minus the almost-full offset, and 1 when more than that offset of locations are free. It is registered on the write clock.
- R8: `aempty_n` is 0 when the stored count is less than or equal to the almost-empty offset, and 1 otherwise.
- R9: A read accepted at a read-clock edge, with `ren`=1 and `empty_n`=1, places the oldest word on `q` at that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst | input | 1 | Active-high reset, synchronous to each clock |
| wen | input | 1 | Write enable |
| load | input | 1 | Steers enabled writes into the offset register |
| din | input | 9 | Write data or offset part |
| ren | input | 1 | Read enable |
| q | output | 9 | Registered read data |
| empty_n | output | 1 | Low when the buffer is empty |
| full_n | output | 1 | Low when the buffer is full |
| aempty_n | output | 1 | Low at or below the almost-empty threshold |
| afull_n | output | 1 | Low at or above the almost-full threshold |

## Verification
A corrupted pointer or a dropped full/empty guard shows up at `q` as a word that is out of order, repeated or missing. That appears at the first read after the fault, and it also shows as a flag that stays wrong once the traffic has settled. A wrong step in the offset-load sequence, or a wrong bit placement, moves a threshold. The almost flags then switch one or more words away from the count the bench expects, and this is seen within a few cycles of both clocks after the word that crosses the threshold. Flags from the other clock domain lag by the two synchronizer stages plus the flag register, so the bench samples them only after that latency.

// File: rtl/fifo_pkg.sv
package fifo_pkg;

    localparam int DATA_W     = 9;
    localparam int PART_W     = 9;
    localparam int GRAY_MAX_W = 32;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [1:0] {
        STEP_AE_LO = 2'd0,
        STEP_AE_HI = 2'd1,
        STEP_AF_LO = 2'd2,
        STEP_AF_HI = 2'd3
    } ofs_step_t;

    function automatic logic [GRAY_MAX_W-1:0] bin_to_gray(input logic [GRAY_MAX_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [GRAY_MAX_W-1:0] gray_to_bin(input logic [GRAY_MAX_W-1:0] g);
        logic [GRAY_MAX_W-1:0] b;
        b[GRAY_MAX_W-1] = g[GRAY_MAX_W-1];
        for (int i = GRAY_MAX_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    function automatic ofs_step_t next_step(input ofs_step_t s);
        case (s)
            STEP_AE_LO: return STEP_AE_HI;
            STEP_AE_HI: return STEP_AF_LO;
            STEP_AF_LO: return STEP_AF_HI;
            default:    return STEP_AE_LO;
        endcase
    endfunction

endpackage

// File: rtl/fifo_sync.sv
module fifo_sync #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/fifo_mem.sv
module fifo_mem
    import fifo_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  word_t         wdata,
    input  logic [AW-1:0] raddr,
    output word_t         rdata
);
    word_t store [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/fifo_ofs_reg.sv
module fifo_ofs_reg
    import fifo_pkg::*;
#(
    parameter int OFS_W  = 9,
    parameter int AE_DEF = 8,
    parameter int AF_DEF = 8
) (
    input  logic             wclk,
    input  logic             rst,
    input  logic             wr,
    input  word_t            din,
    output logic [OFS_W-1:0] ae_ofs,
    output logic [OFS_W-1:0] af_ofs
);
    localparam logic [OFS_W-1:0] AE_INIT = OFS_W'(AE_DEF);
    localparam logic [OFS_W-1:0] AF_INIT = OFS_W'(AF_DEF);

    ofs_step_t step;

    always_ff @(posedge wclk) begin
        if (rst) begin
            step <= STEP_AE_LO;
        end else if (wr) begin
            step <= next_step(step);
        end
    end

    for (genvar b = 0; b < OFS_W; b++) begin : g_bit
        logic ae_b, af_b;
        if (b < PART_W) begin : g_lo
            always_ff @(posedge wclk) begin
                if (rst) begin
                    ae_b <= AE_INIT[b];
                    af_b <= AF_INIT[b];
                end else begin
                    if (wr && step == STEP_AE_LO) ae_b <= din[b];
                    if (wr && step == STEP_AF_LO) af_b <= din[b];
                end
            end
        end else begin : g_hi
            always_ff @(posedge wclk) begin
                if (rst) begin
                    ae_b <= AE_INIT[b];
                    af_b <= AF_INIT[b];
                end else begin
                    if (wr && step == STEP_AE_HI) ae_b <= din[b-PART_W];
                    if (wr && step == STEP_AF_HI) af_b <= din[b-PART_W];
                end
            end
        end
        assign ae_ofs[b] = ae_b;
        assign af_ofs[b] = af_b;
    end
endmodule

// File: rtl/fifo_wr_ctrl.sv
module fifo_wr_ctrl
    import fifo_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int OFS_W = 9,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic             wclk,
    input  logic             rst,
    input  logic             wen,
    input  logic             load,
    input  logic [PW-1:0]    rptr_gray_s,
    input  logic [OFS_W-1:0] af_ofs,
    output logic             mem_we,
    output logic [AW-1:0]    waddr,
    output logic [PW-1:0]    wptr_gray,
    output logic             full_n,
    output logic             afull_n
);
    localparam int CW = ((PW > OFS_W) ? PW : OFS_W) + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    logic [PW-1:0] wptr_q, wptr_nxt, rptr_bin, cnt_nxt;
    logic          push;

    assign rptr_bin = PW'(gray_to_bin(GRAY_MAX_W'(rptr_gray_s)));
    assign push     = wen & ~load & full_n;
    assign wptr_nxt = wptr_q + PW'(push);
    assign cnt_nxt  = wptr_nxt - rptr_bin;

    always_ff @(posedge wclk) begin
        if (rst) begin
            wptr_q    <= '0;
            wptr_gray <= '0;
            full_n    <= 1'b1;
            afull_n   <= 1'b1;
        end else begin
            wptr_q    <= wptr_nxt;
            wptr_gray <= PW'(bin_to_gray(GRAY_MAX_W'(wptr_nxt)));
            full_n    <= (cnt_nxt != DEPTH_P);
            afull_n   <= (CW'(cnt_nxt) + CW'(af_ofs)) < CW'(DEPTH);
        end
    end

    assign mem_we = push;
    assign waddr  = wptr_q[AW-1:0];

    assert_no_overflow_R3: assert property (@(posedge wclk) disable iff (rst)
        (wptr_q - rptr_bin) <= DEPTH_P)
        else $error("R3: write pointer ran past the read pointer");

    assert_full_write_ignored_R3: assert property (@(posedge wclk) disable iff (rst)
        (!full_n && wen && !load) |=> $stable(wptr_q))
        else $error("R3: write accepted while full");

    assert_load_no_push_R5: assert property (@(posedge wclk) disable iff (rst)
        (wen && load) |=> $stable(wptr_q))
        else $error("R5: offset load moved the write pointer");

    assert_full_implies_af_R7: assert property (@(posedge wclk) disable iff (rst)
        !full_n |-> !afull_n)
        else $error("R7: full without almost-full");
endmodule

// File: rtl/fifo_rd_ctrl.sv
module fifo_rd_ctrl
    import fifo_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int OFS_W = 9,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic             rclk,
    input  logic             rst,
    input  logic             ren,
    input  logic [PW-1:0]    wptr_gray_s,
    input  logic [OFS_W-1:0] ae_ofs,
    input  word_t            rdata,
    output logic [AW-1:0]    raddr,
    output logic [PW-1:0]    rptr_gray,
    output word_t            q,
    output logic             empty_n,
    output logic             aempty_n
);
    localparam int CW = ((PW > OFS_W) ? PW : OFS_W) + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    logic [PW-1:0] rptr_q, rptr_nxt, wptr_bin, cnt_nxt;
    logic          pop;

    assign wptr_bin = PW'(gray_to_bin(GRAY_MAX_W'(wptr_gray_s)));
    assign pop      = ren & empty_n;
    assign rptr_nxt = rptr_q + PW'(pop);
    assign cnt_nxt  = wptr_bin - rptr_nxt;

    always_ff @(posedge rclk) begin
        if (rst) begin
            rptr_q    <= '0;
            rptr_gray <= '0;
            q         <= '0;
            empty_n   <= 1'b0;
            aempty_n  <= 1'b0;
        end else begin
            rptr_q    <= rptr_nxt;
            rptr_gray <= PW'(bin_to_gray(GRAY_MAX_W'(rptr_nxt)));
            if (pop) q <= rdata;
            empty_n   <= (cnt_nxt != '0);
            aempty_n  <= CW'(cnt_nxt) > CW'(ae_ofs);
        end
    end

    assign raddr = rptr_q[AW-1:0];

    assert_no_underflow_R4: assert property (@(posedge rclk) disable iff (rst)
        (wptr_bin - rptr_q) <= DEPTH_P)
        else $error("R4: read pointer ran past the write pointer");

    assert_empty_read_hold_R4: assert property (@(posedge rclk) disable iff (rst)
        (!empty_n && ren) |=> ($stable(q) && $stable(rptr_q)))
        else $error("R4: read while empty changed state");

    assert_empty_implies_ae_R8: assert property (@(posedge rclk) disable iff (rst)
        !empty_n |-> !aempty_n)
        else $error("R8: empty without almost-empty");
endmodule

// File: rtl/fifo_pf.sv
module fifo_pf
    import fifo_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int OFS_W  = $clog2(DEPTH) + 1,
    parameter int AE_DEF = 8,
    parameter int AF_DEF = 8
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst,
    input  logic              wen,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    input  logic              ren,
    output logic [DATA_W-1:0] q,
    output logic              empty_n,
    output logic              full_n,
    output logic              aempty_n,
    output logic              afull_n
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [OFS_W-1:0] ae_ofs, af_ofs;
    logic [PW-1:0]    wptr_gray, rptr_gray, wptr_gray_r, rptr_gray_w;
    logic [AW-1:0]    waddr, raddr;
    logic             mem_we;
    word_t            rdata;

    fifo_ofs_reg #(.OFS_W(OFS_W), .AE_DEF(AE_DEF), .AF_DEF(AF_DEF)) u_ofs (
        .wclk(wclk), .rst(rst), .wr(wen & load), .din(din),
        .ae_ofs(ae_ofs), .af_ofs(af_ofs)
    );

    fifo_wr_ctrl #(.DEPTH(DEPTH), .OFS_W(OFS_W)) u_wr (
        .wclk(wclk), .rst(rst), .wen(wen), .load(load),
        .rptr_gray_s(rptr_gray_w), .af_ofs(af_ofs),
        .mem_we(mem_we), .waddr(waddr), .wptr_gray(wptr_gray),
        .full_n(full_n), .afull_n(afull_n)
    );

    fifo_sync #(.W(PW)) u_sync_r2w (
        .clk(wclk), .rst(rst), .d(rptr_gray), .q(rptr_gray_w)
    );

    fifo_sync #(.W(PW)) u_sync_w2r (
        .clk(rclk), .rst(rst), .d(wptr_gray), .q(wptr_gray_r)
    );

    fifo_mem #(.DEPTH(DEPTH)) u_mem (
        .wclk(wclk), .we(mem_we), .waddr(waddr), .wdata(din),
        .raddr(raddr), .rdata(rdata)
    );

    fifo_rd_ctrl #(.DEPTH(DEPTH), .OFS_W(OFS_W)) u_rd (
        .rclk(rclk), .rst(rst), .ren(ren),
        .wptr_gray_s(wptr_gray_r), .ae_ofs(ae_ofs), .rdata(rdata),
        .raddr(raddr), .rptr_gray(rptr_gray), .q(q),
        .empty_n(empty_n), .aempty_n(aempty_n)
    );
endmodule

// File: tb/fifo_pf_bench.sv
module fifo_pf_bench;
    localparam int DEPTH = 256;

    logic       wclk = 1'b0, rclk = 1'b0, rst = 1'b1;
    logic       wen = 1'b0, ren = 1'b0, load = 1'b0;
    logic [8:0] din = '0;
    logic [8:0] q;
    logic       empty_n, full_n, aempty_n, afull_n;

    always #4 wclk = ~wclk;
    always #5 rclk = ~rclk;

    fifo_pf #(.DEPTH(DEPTH)) u_fifo_pf (
        .wclk(wclk), .rclk(rclk), .rst(rst), .wen(wen), .load(load),
        .din(din), .ren(ren), .q(q), .empty_n(empty_n), .full_n(full_n),
        .aempty_n(aempty_n), .afull_n(afull_n)
    );

    int         checks = 0, errors = 0;
    logic [8:0] sb [$];
    logic [8:0] next_val = 9'd0;
    bit         finished = 1'b0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge rclk);
        repeat (6) @(negedge wclk);
    endtask

    task automatic push_word(input logic [8:0] d, input logic ld, output bit ok);
        @(negedge wclk);
        din = d; load = ld; wen = 1'b1;
        ok = full_n;
        if (ok && !ld) sb.push_back(d);
        @(negedge wclk);
        wen = 1'b0; load = 1'b0;
    endtask

    task automatic put_n(input int n);
        bit ok;
        for (int i = 0; i < n; i++) begin
            push_word(next_val, 1'b0, ok);
            next_val = next_val + 9'd1;
        end
    endtask

    task automatic load4(input logic [8:0] a, input logic [8:0] b,
                         input logic [8:0] c, input logic [8:0] d);
        bit ok;
        push_word(a, 1'b1, ok);
        push_word(b, 1'b1, ok);
        push_word(c, 1'b1, ok);
        push_word(d, 1'b1, ok);
    endtask

    // Monitor side of the scoreboard: a read accepted at an edge must show the oldest word after it.
    task automatic pop_word(output bit got);
        logic [8:0] e;
        @(negedge rclk);
        got = 1'b0;
        if (empty_n) begin
            ren = 1'b1;
            e = sb.pop_front();
            got = 1'b1;
            @(negedge rclk);
            ren = 1'b0;
            check("R2 R9 read data", q, e);
        end
    endtask

    task automatic drain_n(input int n);
        bit g;
        int k = 0;
        while (k < n) begin
            pop_word(g);
            if (g) k++;
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge wclk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [8:0] last;
        repeat (6) @(negedge wclk);
        check("R1 empty_n in reset", empty_n, 0);
        rst = 1'b0;
        @(negedge rclk);
        check("R1 empty_n", empty_n, 0);
        check("R1 aempty_n", aempty_n, 0);
        check("R1 full_n", full_n, 1);
        check("R1 afull_n", afull_n, 1);

        // default almost-empty offset 8
        put_n(8); settle();
        check("R1 default ae at 8 words", aempty_n, 0);
        check("R4 empty_n with words", empty_n, 1);
        put_n(1); settle();
        check("R1 default ae at 9 words", aempty_n, 1);
        check("R1 afull_n at 9 words", afull_n, 1);
        drain_n(9); settle();
        check("R4 empty after drain", empty_n, 0);
        check("R8 aempty after drain", aempty_n, 0);

        // reads while empty are dropped, q holds
        last = q;
        repeat (3) begin @(negedge rclk); ren = 1'b1; end
        @(negedge rclk); ren = 1'b0;
        check("R4 q held on empty reads", q, last);
        check("R4 still empty", empty_n, 0);

        // program thresholds: ae=16, af=20
        load4(9'd16, 9'd0, 9'd20, 9'd0); settle();
        check("R5 load writes not stored", empty_n, 0);
        put_n(1); drain_n(1); settle();
        check("R5 only the real word stored", empty_n, 0);

        put_n(16); settle();
        check("R8 ae at 16 words", aempty_n, 0);
        put_n(1); settle();
        check("R8 ae at 17 words", aempty_n, 1);
        put_n(218); settle();
        check("R7 af at 235 words", afull_n, 1);
        put_n(1); settle();
        check("R7 af at 236 words", afull_n, 0);
        check("R3 not full at 236", full_n, 1);
        put_n(19); settle();
        check("R3 not full at 255", full_n, 1);
        put_n(1); settle();
        check("R3 full at 256", full_n, 0);
        put_n(3); settle();
        check("R3 still full after dropped writes", full_n, 0);

        drain_n(20); settle();
        check("R7 af still low at 236", afull_n, 0);
        drain_n(1); settle();
        check("R7 af high with 21 free", afull_n, 1);
        check("R3 full released", full_n, 1);
        drain_n(235); settle();
        check("R3 dropped writes never read", empty_n, 0);
        check("R3 scoreboard empty", sb.size(), 0);

        // sequence wraps to ae low; high part beyond width ignored; af=5
        load4(9'd4, 9'd1, 9'd5, 9'd0);
        put_n(4); settle();
        check("R6 ae at 4 words", aempty_n, 0);
        put_n(1); settle();
        check("R6 ae at 5 words", aempty_n, 1);
        put_n(245); settle();
        check("R6 af at 250 words", afull_n, 1);
        put_n(1); settle();
        check("R6 af at 251 words", afull_n, 0);
        drain_n(251); settle();
        check("R6 drained", empty_n, 0);

        // concurrent streaming across wrap-around
        fork
            begin
                bit ok;
                for (int i = 0; i < 300; i++) begin
                    ok = 1'b0;
                    while (!ok) push_word(next_val, 1'b0, ok);
                    next_val = next_val + 9'd1;
                end
            end
            begin
                drain_n(300);
            end
        join
        settle();
        check("R2 stream drained", empty_n, 0);
        check("R2 stream scoreboard empty", sb.size(), 0);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule